// File: doc/BRIEF.md
# Serial Wire-Mode Output Controller

This block sits on the pin side of a general-purpose serial interface. A 2-bit wire-mode input picks one of four behaviours for three pins: a data-in/two-wire data pin (SDA), a data-out pin (DO) and a clock pin (SCK/SCL). The block turns the port value bits, the direction bits and the shift register's most significant bit into a drive-enable, drive-value and pull-up request for each pin. In the two-wire modes the data and clock pins are open-drain: the driver is only enabled to pull low. The sampled line inputs are not changed by the mode. They feed a start detector and a clock-edge detector that set a start flag.

Two sticky flags are kept: a start flag and a counter-overflow flag. Each flag is cleared by a one-cycle software clear pulse. A clear wins over a set in the same cycle. In either two-wire mode a set start flag stretches the clock by pulling SCL low. In the two-wire-with-overflow-hold mode a set overflow flag also does this. The flags live in a four-state machine:
- `FL_IDLE`: no flag set.
- `FL_START`: start flag only.
- `FL_OVF`: overflow flag only.
- `FL_BOTH`: both flags set.

The transitions are:
- Set-start: from IDLE to START, or from OVF to BOTH.
- Set-overflow: from IDLE to OVF, or from START to BOTH.
- Clear-start: from START to IDLE, or from BOTH to OVF.
- Clear-overflow: from OVF to IDLE, or from BOTH to START.
- Both events can land in the same cycle and combine. For example, a set-start together with a clear-overflow moves the machine from OVF to START.
- Otherwise the machine holds its state.

Top module: `swm_out_ctrl`

## Requirements
- R1: After reset both flags are 0, the clock hold is inactive, and the pins follow the port-mode rules of R2 for the applied port and direction bits.
- R2: With mode 2'b00, each of the three pins has enable equal to its direction bit and value equal to its port bit. Its pull-up request is high only when the direction bit is 0 and the port bit is 1. The shift register MSB has no effect on any pin.
- R3: With mode 2'b01, the DO pin drives the shift register MSB in place of its port bit, and its enable is still its direction bit. The DO pull-up follows the R2 rule. The SDA and SCL pins behave as in R2.
- R4: With mode 2'b10 or 2'b11, the SDA enable is its direction bit ANDed with NOT(MSB AND SDA port bit), and the SDA drive value is 0. The SDA and SCL pull-up requests are 0. The DO pin behaves as in R2.
- R5: In the two-wire modes, the SCL enable is its direction bit ANDed with (NOT SCL port bit OR clock hold), and the SCL drive value is 0.
- R6: In the two-wire modes, a start condition sets the start flag at the next clock edge. A start condition is SDA sampled 1 at one edge and 0 at the next, with SCL sampled 1 at both edges. The flag then stays set and the clock hold is active, whatever the lines do afterwards.
- R7: A start-clear pulse clears the start flag at the next edge, which releases the start hold. A clear in the same cycle as a start condition leaves the flag 0.
- R8: An overflow pulse sets the overflow flag in every mode, and an overflow-clear pulse clears it, winning over a simultaneous pulse. The overflow flag activates the clock hold only in mode 2'b11.
- R9: In modes 2'b00 and 2'b01 the clock hold is inactive. If the clock-source select is 2'b10 or 2'b11 and the software-clock select is 0, any change of the sampled SCL line between edges sets the start flag. With any other select value, such a change does not set it.
- R10: An SDA fall with SCL high does not set the start flag in mode 2'b00. An SCL change alone does not set it in the two-wire modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Wire-mode select |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_in | input | 1 | Sampled level of the SCL line |
| sr_msb | input | 1 | Shift register most significant bit |
| port_sda | input | 1 | Port value bit of the SDA pin |
| port_do | input | 1 | Port value bit of the DO pin |
| port_scl | input | 1 | Port value bit of the SCL pin |
| dir_sda | input | 1 | Direction bit of the SDA pin (1 = output) |
| dir_do | input | 1 | Direction bit of the DO pin |
| dir_scl | input | 1 | Direction bit of the SCL pin |
| clk_src | input | 2 | Clock-source select |
| clk_soft | input | 1 | Software-clock select bit |
| ovf_pulse | input | 1 | Counter-overflow pulse |
| start_clr | input | 1 | Start-flag clear pulse |
| ovf_clr | input | 1 | Overflow-flag clear pulse |
| start_flag | output | 1 | Start flag |
| ovf_flag | output | 1 | Overflow flag |
| scl_hold | output | 1 | Clock hold active |
| sda_oe | output | 1 | SDA drive enable |
| sda_out | output | 1 | SDA drive value |
| sda_pu | output | 1 | SDA pull-up request |
| do_oe | output | 1 | DO drive enable |
| do_out | output | 1 | DO drive value |
| do_pu | output | 1 | DO pull-up request |
| scl_oe | output | 1 | SCL drive enable |
| scl_out | output | 1 | SCL drive value |
| scl_pu | output | 1 | SCL pull-up request |

## Verification
The hardest case to reach is a start condition that arrives in the same cycle as the start-clear pulse. The stimulus first parks both lines high for one edge. It then drops SDA while keeping SCL high and raises the clear pulse for exactly that cycle. Another hard case is moving from mode 2'b10 to 2'b11 with the overflow flag already set. The stimulus sets the flag in mode 2'b10 and then switches the mode. The clock pull must appear with the mode change alone, with no new overflow event.

// File: rtl/swm_pkg.sv
`timescale 1ns/1ps
package swm_pkg;
    typedef enum logic [1:0] {
        WM_OFF     = 2'b00,
        WM_THREE   = 2'b01,
        WM_TWO     = 2'b10,
        WM_TWO_OVF = 2'b11
    } wire_mode_e;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_START,
        FL_OVF,
        FL_BOTH
    } flag_state_e;

    typedef struct packed {
        logic oe;
        logic val;
        logic pu;
    } pin_drv_t;

    localparam int MODE_W = 2;
    localparam int CSEL_W = 2;
endpackage

// File: rtl/swm_start_det.sv
`timescale 1ns/1ps
module swm_start_det
    import swm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic [CSEL_W-1:0] clk_src,
    input  logic              clk_soft,
    output logic              start_set
);
    logic sda_q;
    logic scl_q;
    logic two_wire;

    // Lines are assumed idle-high coming out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q <= 1'b1;
            scl_q <= 1'b1;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
        end
    end

    assign two_wire = mode[1];

    always_comb begin
        if (two_wire) begin
            // falling data with the clock high on both samples
            start_set = sda_q & ~sda_in & scl_q & scl_in;
        end else begin
            // external-clock selections: any clock-pin edge
            start_set = clk_src[1] & ~clk_soft & (scl_q ^ scl_in);
        end
    end
endmodule

// File: rtl/swm_flag_fsm.sv
`timescale 1ns/1ps
module swm_flag_fsm
    import swm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              start_set,
    input  logic              start_clr,
    input  logic              ovf_pulse,
    input  logic              ovf_clr,
    output logic              start_flag,
    output logic              ovf_flag,
    output logic              scl_hold
);
    flag_state_e state_q;
    flag_state_e state_d;
    logic        s_nxt;
    logic        o_nxt;

    always_comb begin
        s_nxt = 1'b0;
        o_nxt = 1'b0;
        unique case (state_q)
            FL_IDLE:  begin s_nxt = start_set; o_nxt = ovf_pulse; end
            FL_START: begin s_nxt = 1'b1;      o_nxt = ovf_pulse; end
            FL_OVF:   begin s_nxt = start_set; o_nxt = 1'b1;      end
            FL_BOTH:  begin s_nxt = 1'b1;      o_nxt = 1'b1;      end
        endcase
        // software clears beat same-cycle set events
        s_nxt = s_nxt & ~start_clr;
        o_nxt = o_nxt & ~ovf_clr;
        state_d = s_nxt ? (o_nxt ? FL_BOTH : FL_START)
                        : (o_nxt ? FL_OVF  : FL_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start_flag = 1'b0;
        ovf_flag   = 1'b0;
        unique case (state_q)
            FL_IDLE:  begin start_flag = 1'b0; ovf_flag = 1'b0; end
            FL_START: begin start_flag = 1'b1; ovf_flag = 1'b0; end
            FL_OVF:   begin start_flag = 1'b0; ovf_flag = 1'b1; end
            FL_BOTH:  begin start_flag = 1'b1; ovf_flag = 1'b1; end
        endcase
        scl_hold = (mode[1] & start_flag)
                 | ((mode == WM_TWO_OVF) & ovf_flag);
    end
endmodule

// File: rtl/swm_pin_mux.sv
`timescale 1ns/1ps
module swm_pin_mux
    import swm_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              sr_msb,
    input  logic              scl_hold,
    input  logic              port_sda,
    input  logic              port_do,
    input  logic              port_scl,
    input  logic              dir_sda,
    input  logic              dir_do,
    input  logic              dir_scl,
    output pin_drv_t          sda_drv,
    output pin_drv_t          do_drv,
    output pin_drv_t          scl_drv
);
    logic two_wire;
    assign two_wire = mode[1];

    always_comb begin
        // plain port behaviour by default
        sda_drv = '{oe: dir_sda, val: port_sda, pu: ~dir_sda & port_sda};
        do_drv  = '{oe: dir_do,  val: port_do,  pu: ~dir_do  & port_do};
        scl_drv = '{oe: dir_scl, val: port_scl, pu: ~dir_scl & port_scl};

        if (mode == WM_THREE) begin
            do_drv.val = sr_msb;
        end

        if (two_wire) begin
            sda_drv = '{oe: dir_sda & ~(sr_msb & port_sda), val: 1'b0, pu: 1'b0};
            scl_drv = '{oe: dir_scl & (~port_scl | scl_hold), val: 1'b0, pu: 1'b0};
        end
    end
endmodule

// File: rtl/swm_out_ctrl.sv
`timescale 1ns/1ps
module swm_out_ctrl
    import swm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic       sr_msb,
    input  logic       port_sda,
    input  logic       port_do,
    input  logic       port_scl,
    input  logic       dir_sda,
    input  logic       dir_do,
    input  logic       dir_scl,
    input  logic [1:0] clk_src,
    input  logic       clk_soft,
    input  logic       ovf_pulse,
    input  logic       start_clr,
    input  logic       ovf_clr,
    output logic       start_flag,
    output logic       ovf_flag,
    output logic       scl_hold,
    output logic       sda_oe,
    output logic       sda_out,
    output logic       sda_pu,
    output logic       do_oe,
    output logic       do_out,
    output logic       do_pu,
    output logic       scl_oe,
    output logic       scl_out,
    output logic       scl_pu
);
    logic     start_set;
    pin_drv_t sda_drv;
    pin_drv_t do_drv;
    pin_drv_t scl_drv;

    swm_start_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .clk_src   (clk_src),
        .clk_soft  (clk_soft),
        .start_set (start_set)
    );

    swm_flag_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .start_set  (start_set),
        .start_clr  (start_clr),
        .ovf_pulse  (ovf_pulse),
        .ovf_clr    (ovf_clr),
        .start_flag (start_flag),
        .ovf_flag   (ovf_flag),
        .scl_hold   (scl_hold)
    );

    swm_pin_mux u_mux (
        .mode     (mode),
        .sr_msb   (sr_msb),
        .scl_hold (scl_hold),
        .port_sda (port_sda),
        .port_do  (port_do),
        .port_scl (port_scl),
        .dir_sda  (dir_sda),
        .dir_do   (dir_do),
        .dir_scl  (dir_scl),
        .sda_drv  (sda_drv),
        .do_drv   (do_drv),
        .scl_drv  (scl_drv)
    );

    assign sda_oe  = sda_drv.oe;
    assign sda_out = sda_drv.val;
    assign sda_pu  = sda_drv.pu;
    assign do_oe   = do_drv.oe;
    assign do_out  = do_drv.val;
    assign do_pu   = do_drv.pu;
    assign scl_oe  = scl_drv.oe;
    assign scl_out = scl_drv.val;
    assign scl_pu  = scl_drv.pu;
endmodule

module swm_out_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       dir_scl,
    input logic       ovf_pulse,
    input logic       start_clr,
    input logic       ovf_clr,
    input logic       start_flag,
    input logic       ovf_flag,
    input logic       scl_hold,
    input logic       sda_out,
    input logic       sda_pu,
    input logic       scl_oe,
    input logic       scl_out,
    input logic       scl_pu
);
    p_tw_no_pullup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (!sda_pu && !scl_pu && !sda_out));

    p_hold_pulls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && scl_hold && dir_scl) |-> (scl_oe && !scl_out));

    p_start_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && !start_clr) |=> start_flag);

    p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> !start_flag);

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && !ovf_clr) |=> ovf_flag);

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> !ovf_flag);

    p_no_hold_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> !scl_hold);
endmodule

bind swm_out_ctrl swm_out_ctrl_chk u_chk (.*);

// File: tb/test_swm_out_ctrl.sv
`timescale 1ns/1ps
module test_swm_out_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic sda_in = 1'b1, scl_in = 1'b1, sr_msb = 1'b0;
    logic port_sda = 1'b0, port_do = 1'b0, port_scl = 1'b0;
    logic dir_sda = 1'b0, dir_do = 1'b0, dir_scl = 1'b0;
    logic [1:0] clk_src = 2'b00;
    logic clk_soft = 1'b0, ovf_pulse = 1'b0, start_clr = 1'b0, ovf_clr = 1'b0;
    logic start_flag, ovf_flag, scl_hold;
    logic sda_oe, sda_out, sda_pu, do_oe, do_out, do_pu, scl_oe, scl_out, scl_pu;

    int checks = 0;
    int fails = 0;

    // expected-state model kept from the requirements
    logic m_s = 1'b0, m_o = 1'b0, m_sda = 1'b1, m_scl = 1'b1;

    typedef struct {
        logic [11:0] v;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    swm_out_ctrl i_swm_out_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sda_in(sda_in), .scl_in(scl_in),
        .sr_msb(sr_msb), .port_sda(port_sda), .port_do(port_do), .port_scl(port_scl),
        .dir_sda(dir_sda), .dir_do(dir_do), .dir_scl(dir_scl), .clk_src(clk_src),
        .clk_soft(clk_soft), .ovf_pulse(ovf_pulse), .start_clr(start_clr),
        .ovf_clr(ovf_clr), .start_flag(start_flag), .ovf_flag(ovf_flag),
        .scl_hold(scl_hold), .sda_oe(sda_oe), .sda_out(sda_out), .sda_pu(sda_pu),
        .do_oe(do_oe), .do_out(do_out), .do_pu(do_pu), .scl_oe(scl_oe),
        .scl_out(scl_out), .scl_pu(scl_pu)
    );

    function automatic logic [11:0] model_out();
        logic tw, hold;
        logic [2:0] s, d, c;
        tw   = mode[1];
        hold = (tw && m_s) || (mode == 2'b11 && m_o);
        s = tw ? {dir_sda & ~(sr_msb & port_sda), 1'b0, 1'b0}
               : {dir_sda, port_sda, ~dir_sda & port_sda};
        d = {dir_do, (mode == 2'b01) ? sr_msb : port_do, ~dir_do & port_do};
        c = tw ? {dir_scl & (~port_scl | hold), 1'b0, 1'b0}
               : {dir_scl, port_scl, ~dir_scl & port_scl};
        return {m_s, m_o, hold, s, d, c};
    endfunction

    function automatic logic [11:0] dut_out();
        return {start_flag, ovf_flag, scl_hold, sda_oe, sda_out, sda_pu,
                do_oe, do_out, do_pu, scl_oe, scl_out, scl_pu};
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // driver: apply current inputs over one edge, push the expectation
    task automatic step(input string req);
        logic ss;
        @(posedge clk);
        ss = mode[1] ? (m_sda & ~sda_in & m_scl & scl_in)
                     : (clk_src[1] & ~clk_soft & (m_scl ^ scl_in));
        m_s = ~start_clr & (m_s | ss);
        m_o = ~ovf_clr & (m_o | ovf_pulse);
        m_sda = sda_in;
        m_scl = scl_in;
        exp_q.push_back('{model_out(), req});
        @(negedge clk);
        #1;
        ovf_pulse = 1'b0;
        start_clr = 1'b0;
        ovf_clr   = 1'b0;
    endtask

    // monitor: compare at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [11:0] got;
                e   = exp_q.pop_front();
                got = dut_out();
                checks++;
                if (got !== e.v) begin
                    fails++;
                    $display("FAIL %s got %b expected %b", e.req, got, e.v);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog (all requirements) got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        port_sda = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        checks++;
        if (dut_out() !== model_out()) begin
            fails++;
            $display("FAIL R1 got %b expected %b", dut_out(), model_out());
        end

        // R2: port mode, MSB set to show it is ignored
        sr_msb = 1'b1;
        for (int i = 0; i < 64; i++) begin
            {port_sda, port_do, port_scl, dir_sda, dir_do, dir_scl} = i[5:0];
            step("R2");
        end

        // R10: data fall with clock high in mode 00
        sda_in = 1'b1; scl_in = 1'b1; step("R10");
        sda_in = 1'b0; step("R10");
        sda_in = 1'b1; step("R10");

        // R3: three-wire
        mode = 2'b01;
        for (int i = 0; i < 32; i++) begin
            {sr_msb, port_do, dir_do, port_sda, dir_scl} = i[4:0];
            step("R3");
        end

        // R4: two-wire data pin
        mode = 2'b10;
        for (int i = 0; i < 16; i++) begin
            {sr_msb, port_sda, dir_sda, port_do} = i[3:0];
            dir_do = i[0];
            step("R4");
        end
        // R5: two-wire clock pin
        for (int i = 0; i < 4; i++) begin
            {port_scl, dir_scl} = i[1:0];
            step("R5");
        end

        // R6: start condition and hold
        dir_scl = 1'b1; port_scl = 1'b1;
        sda_in = 1'b1; scl_in = 1'b1; step("R6");
        sda_in = 1'b0; step("R6");
        scl_in = 1'b0; step("R6");
        sda_in = 1'b1; step("R6");
        dir_scl = 1'b0; step("R6");
        dir_scl = 1'b1;

        // R7: clear, then clear colliding with a start
        start_clr = 1'b1; step("R7");
        scl_in = 1'b1; sda_in = 1'b1; step("R7");
        sda_in = 1'b0; start_clr = 1'b1; step("R7");
        step("R7");

        // R10: clock edges alone in two-wire, external-clock select set
        clk_src = 2'b10;
        scl_in = 1'b0; step("R10");
        scl_in = 1'b1; step("R10");
        clk_src = 2'b00;

        // R8: overflow flag and hold
        ovf_pulse = 1'b1; step("R8");
        step("R8");
        mode = 2'b11; step("R8");
        ovf_clr = 1'b1; step("R8");
        ovf_pulse = 1'b1; ovf_clr = 1'b1; step("R8");
        ovf_pulse = 1'b1; step("R8");
        mode = 2'b00; step("R8");
        ovf_clr = 1'b1; step("R8");

        // R9: clock-edge start in port modes
        sda_in = 1'b1; step("R9");
        sda_in = 1'b0; scl_in = 1'b1; mode = 2'b11; step("R9");
        sda_in = 1'b1; step("R9");
        sda_in = 1'b0; step("R9");
        mode = 2'b00; step("R9");
        start_clr = 1'b1; step("R9");
        clk_src = 2'b10; clk_soft = 1'b0;
        scl_in = 1'b0; step("R9");
        start_clr = 1'b1; step("R9");
        mode = 2'b01; clk_src = 2'b11;
        scl_in = 1'b1; step("R9");
        start_clr = 1'b1; step("R9");
        clk_src = 2'b01;
        scl_in = 1'b0; step("R9");
        scl_in = 1'b1; step("R9");
        clk_src = 2'b10; clk_soft = 1'b1;
        scl_in = 1'b0; step("R9");
        mode = 2'b00;
        scl_in = 1'b1; step("R9");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule